// File: doc/BRIEF.md
# Functional Unit Token Controller

This block sits on the control side of one functional unit in a coarse-grained reconfigurable array. It takes in a network of 1-bit tokens that has the same shape as the datapath. A token on a link says that a value will arrive on the matching datapath wire in the following cycle. The controller works out the operand multiplexer selects from which links carry a token, so the configuration memory holds no source-select field. It reads the compressed configuration word only in a cycle when the unit has work to do.

The word it reads holds an opcode, two destination codes and a guard flag. The block gives the datapath a valid strobe, the operand selects and the opcode one cycle after the tokens arrive. The opcode sets two things: whether the outgoing token is a data token or a predicate token, and whether it leaves after one cycle or two. The block then sends registered tokens to the destinations named in the word. Each token carries a staging predicate. The first operations of a software-pipelined loop body use it to suppress themselves during the fill and drain phases.

Top module: `fu_token_unit`

## Requirements
- R1: In a cycle where any bit of `in_tok` is high, `fetch_en` is high and `fetch_addr` equals `cfg_slot` in that same cycle. With no token present, `fetch_en` stays low.
- R2: Token bit `o*LINKS+l` stands for link `l` of operand `o`. One cycle after the tokens arrive, `exec_sel[o*SEL_W +: SEL_W]` holds the link number that carried the token for operand `o`. An operand with no token gets select 0.
- R3: If two or more links of one operand carry a token in the same cycle, `sel_err` is high in the following cycle and the select is the lowest-numbered of those links. Otherwise `sel_err` is low.
- R4: `exec_valid` goes high exactly one cycle after a token cycle, and only then. In that cycle `exec_opcode` equals `fetch_data[OPC_W-1:0]`.
- R5: In a cycle that does not follow a token cycle, `exec_opcode` keeps the last fetched opcode, whatever is on `fetch_data`.
- R6: The destination codes are `fetch_data[OPC_W +: DCODE_W]` and `fetch_data[OPC_W+DCODE_W +: DCODE_W]`. Code 0 names no destination. Code k sends a token on `out_tok[k-1]`. Both slots may fire, and two equal codes give a single bit.
- R7: Opcode bit `OPC_W-2` chooses the latency. When it is 0, the outgoing tokens appear two cycles after the token cycle. When it is 1, they appear three cycles after it. Tokens from different operations that fall due in the same cycle are merged by OR.
- R8: Opcode bit `OPC_W-1` marks a predicate result. When it is set, `out_pred` is high on every link where that operation's token goes out. When it is clear, `out_pred` stays low on those links.
- R9: `exec_stage` is the AND of the `in_stage` bits on the selected link of every operand that had a token. `out_stage` is high on an outgoing link exactly when the operation that produced it had a high stage.
- R10: If the guard flag `fetch_data[CFG_W-1]` is set and the combined stage is low, then `exec_valid` stays low and no tokens are sent. If the flag is clear, a low stage does not suppress execution.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slot | input | ADDR_W | Current schedule slot, used as the fetch address |
| in_tok | input | OPS*LINKS | Incoming token per operand link |
| in_stage | input | OPS*LINKS | Staging predicate travelling with each token |
| fetch_en | output | 1 | Configuration read request |
| fetch_addr | output | ADDR_W | Configuration read address |
| fetch_data | input | CFG_W | Configuration word, returned one cycle after the request |
| exec_valid | output | 1 | Datapath executes this cycle |
| exec_sel | output | OPS*SEL_W | Operand multiplexer selects |
| exec_opcode | output | OPC_W | Opcode for the datapath |
| exec_stage | output | 1 | Combined staging predicate of the current operation |
| sel_err | output | 1 | More than one token arrived for one operand |
| out_tok | output | NDEST | Outgoing tokens per neighbour link |
| out_pred | output | NDEST | Outgoing token is a predicate token |
| out_stage | output | NDEST | Staging predicate sent with each outgoing token |

## Verification
The bench tries several token shapes, each of which separates a different fault:
- a single token on link 0, which gives the basic fetch, valid and latency behaviour;
- tokens on high-numbered links of both operands, which checks the select encoding and the operand order;
- several tokens on one operand, which checks the priority choice and the error flag;
- a word with no destinations, which checks that the null code sends nothing.

Stage patterns are crossed with the guard flag. This separates a guarded operation that is suppressed from an unguarded one that only carries a low stage, and it shows whether the stage AND follows the selected link. A long-latency operation is followed at once by a short one. This shows whether tokens that fall due in the same cycle merge or are lost. Junk on `fetch_data` in idle cycles shows whether the opcode is held.

// File: rtl/fu_tok_pkg.sv
package fu_tok_pkg;

  // Kind of token a result sends downstream.
  typedef enum logic {
    TOK_DATA = 1'b0,
    TOK_PRED = 1'b1
  } tok_kind_e;

  // Cycles from execute to the token being emitted (registered).
  typedef enum logic {
    LAT_ONE = 1'b0,
    LAT_TWO = 1'b1
  } tok_lat_e;

endpackage

// File: rtl/fu_tok_select.sv
module fu_tok_select #(
  parameter int LINKS = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINKS-1:0] tok_i,
  input  logic [LINKS-1:0] stage_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             hit_o,
  output logic             multi_o,
  output logic             stage_o
);

  // Lowest-numbered active link wins.
  always_comb begin
    sel_o   = '0;
    hit_o   = 1'b0;
    stage_o = 1'b1;
    for (int l = LINKS - 1; l >= 0; l--) begin
      if (tok_i[l]) begin
        sel_o   = SEL_W'(l);
        hit_o   = 1'b1;
        stage_o = stage_i[l];
      end
    end
  end

  // More than one bit set: clearing the lowest set bit leaves something.
  assign multi_o = |(tok_i & (tok_i - LINKS'(1)));

  assert_multi_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tok_i) > 1) |-> multi_o);

  assert_sel_on_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (tok_i[sel_o] && ((tok_i & ((LINKS'(1) << sel_o) - LINKS'(1))) == '0)));

endmodule

// File: rtl/fu_tok_launch.sv
module fu_tok_launch
  import fu_tok_pkg::*;
#(
  parameter int NDEST   = 6,
  parameter int DCODE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_i,
  input  tok_lat_e           lat_i,
  input  tok_kind_e          kind_i,
  input  logic               stage_i,
  input  logic [DCODE_W-1:0] dcode0_i,
  input  logic [DCODE_W-1:0] dcode1_i,
  output logic [NDEST-1:0]   out_tok_o,
  output logic [NDEST-1:0]   out_pred_o,
  output logic [NDEST-1:0]   out_stage_o
);

  function automatic logic [NDEST-1:0] dest_dec(input logic [DCODE_W-1:0] code);
    logic [NDEST-1:0] v;
    v = '0;
    for (int k = 0; k < NDEST; k++) begin
      if (code == DCODE_W'(k + 1)) v[k] = 1'b1;
    end
    return v;
  endfunction

  logic [NDEST-1:0] vec, now_tok, late_tok_d, late_tok_q;
  logic [NDEST-1:0] late_pred_d, late_pred_q, late_stage_d, late_stage_q;
  logic [NDEST-1:0] tok_d, pred_d, stage_d;
  logic             is_pred;

  assign is_pred = (kind_i == TOK_PRED);

  always_comb begin
    vec          = launch_i ? (dest_dec(dcode0_i) | dest_dec(dcode1_i)) : '0;
    now_tok      = (lat_i == LAT_ONE) ? vec : '0;
    late_tok_d   = (lat_i == LAT_TWO) ? vec : '0;
    late_pred_d  = is_pred ? late_tok_d : '0;
    late_stage_d = stage_i ? late_tok_d : '0;
    tok_d        = now_tok | late_tok_q;
    pred_d       = (is_pred ? now_tok : '0) | late_pred_q;
    stage_d      = (stage_i ? now_tok : '0) | late_stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_tok_q   <= '0;
      late_pred_q  <= '0;
      late_stage_q <= '0;
      out_tok_o    <= '0;
      out_pred_o   <= '0;
      out_stage_o  <= '0;
    end else begin
      late_tok_q   <= late_tok_d;
      late_pred_q  <= late_pred_d;
      late_stage_q <= late_stage_d;
      out_tok_o    <= tok_d;
      out_pred_o   <= pred_d;
      out_stage_o  <= stage_d;
    end
  end

  assert_short_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && lat_i == LAT_ONE && dcode0_i != '0 && dcode0_i <= DCODE_W'(NDEST))
      |=> out_tok_o != '0);

  assert_long_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && lat_i == LAT_TWO && dcode0_i != '0 && dcode0_i <= DCODE_W'(NDEST))
      |=> ##1 out_tok_o != '0);

  assert_pred_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pred_o & ~out_tok_o) == '0);

endmodule

// File: rtl/fu_token_unit.sv
module fu_token_unit
  import fu_tok_pkg::*;
#(
  parameter int LINKS   = 4,
  parameter int OPS     = 2,
  parameter int OPC_W   = 6,
  parameter int ADDR_W  = 5,
  parameter int NDEST   = 6,
  localparam int SEL_W   = (LINKS > 1) ? $clog2(LINKS) : 1,
  localparam int DCODE_W = $clog2(NDEST + 1),
  localparam int CFG_W   = OPC_W + 2 * DCODE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_slot,
  input  logic [OPS*LINKS-1:0] in_tok,
  input  logic [OPS*LINKS-1:0] in_stage,
  output logic                 fetch_en,
  output logic [ADDR_W-1:0]    fetch_addr,
  input  logic [CFG_W-1:0]     fetch_data,
  output logic                 exec_valid,
  output logic [OPS*SEL_W-1:0] exec_sel,
  output logic [OPC_W-1:0]     exec_opcode,
  output logic                 exec_stage,
  output logic                 sel_err,
  output logic [NDEST-1:0]     out_tok,
  output logic [NDEST-1:0]     out_pred,
  output logic [NDEST-1:0]     out_stage
);

  logic [OPS-1:0]       hit, multi, op_stage;
  logic [OPS*SEL_W-1:0] sel_c;

  for (genvar g = 0; g < OPS; g++) begin : g_op
    fu_tok_select #(.LINKS(LINKS), .SEL_W(SEL_W)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .tok_i   (in_tok[g*LINKS +: LINKS]),
      .stage_i (in_stage[g*LINKS +: LINKS]),
      .sel_o   (sel_c[g*SEL_W +: SEL_W]),
      .hit_o   (hit[g]),
      .multi_o (multi[g]),
      .stage_o (op_stage[g])
    );
  end

  // Configuration word fields.
  logic [OPC_W-1:0]   f_opc;
  logic [DCODE_W-1:0] f_d0, f_d1;
  logic               f_top;
  assign f_opc = fetch_data[OPC_W-1:0];
  assign f_d0  = fetch_data[OPC_W +: DCODE_W];
  assign f_d1  = fetch_data[OPC_W+DCODE_W +: DCODE_W];
  assign f_top = fetch_data[CFG_W-1];

  logic                 fire;
  logic                 fire_q, fire_d;
  logic [OPS*SEL_W-1:0] sel_q, sel_d;
  logic                 err_q, err_d;
  logic                 stage_q, stage_d;
  logic [OPC_W-1:0]     hold_q, hold_d;

  assign fire = |hit;

  // Next-state process.
  always_comb begin
    fire_d  = fire;
    err_d   = |multi;
    sel_d   = sel_q;
    stage_d = stage_q;
    hold_d  = hold_q;
    if (fire) begin
      sel_d   = sel_c;
      stage_d = &op_stage;
    end
    if (fire_q) begin
      hold_d = f_opc;
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q  <= 1'b0;
      err_q   <= 1'b0;
      sel_q   <= '0;
      stage_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      fire_q  <= fire_d;
      err_q   <= err_d;
      sel_q   <= sel_d;
      stage_q <= stage_d;
      hold_q  <= hold_d;
    end
  end

  assign fetch_en    = fire;
  assign fetch_addr  = fire ? cfg_slot : '0;
  assign exec_valid  = fire_q & (~f_top | stage_q);
  assign exec_sel    = sel_q;
  assign exec_opcode = fire_q ? f_opc : hold_q;
  assign exec_stage  = stage_q;
  assign sel_err     = err_q;

  fu_tok_launch #(.NDEST(NDEST), .DCODE_W(DCODE_W)) u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (exec_valid),
    .lat_i       (tok_lat_e'(f_opc[OPC_W-2])),
    .kind_i      (tok_kind_e'(f_opc[OPC_W-1])),
    .stage_i     (stage_q),
    .dcode0_i    (f_d0),
    .dcode1_i    (f_d1),
    .out_tok_o   (out_tok),
    .out_pred_o  (out_pred),
    .out_stage_o (out_stage)
  );

  assert_valid_follows_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> $past(fetch_en));

  assert_idle_no_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> !exec_valid);

  assert_opcode_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !$past(fetch_en)) |=> $stable(exec_opcode));

  assert_guard_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (f_top && !exec_stage) |-> !exec_valid);

endmodule

// File: tb/fu_token_unit_tb.sv
module fu_token_unit_tb;

  localparam int LINKS = 4, OPS = 2, OPC_W = 6, ADDR_W = 5, NDEST = 6;
  localparam int SEL_W = 2, CFG_W = 13;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [ADDR_W-1:0]    cfg_slot;
  logic [OPS*LINKS-1:0] in_tok, in_stage;
  logic                 fetch_en;
  logic [ADDR_W-1:0]    fetch_addr;
  logic [CFG_W-1:0]     fetch_data;
  logic                 exec_valid, exec_stage, sel_err;
  logic [OPS*SEL_W-1:0] exec_sel;
  logic [OPC_W-1:0]     exec_opcode;
  logic [NDEST-1:0]     out_tok, out_pred, out_stage;

  always #2.5 clk = ~clk;

  fu_token_unit #(.LINKS(LINKS), .OPS(OPS), .OPC_W(OPC_W), .ADDR_W(ADDR_W), .NDEST(NDEST)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_slot(cfg_slot), .in_tok(in_tok), .in_stage(in_stage),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .exec_valid(exec_valid), .exec_sel(exec_sel), .exec_opcode(exec_opcode),
    .exec_stage(exec_stage), .sel_err(sel_err),
    .out_tok(out_tok), .out_pred(out_pred), .out_stage(out_stage)
  );

  typedef struct packed {
    logic [7:0]  tok;
    logic [7:0]  stg;
    logic [12:0] data;
    logic [3:0]  sel;
    logic        err;
    logic        vld;
    logic        estg;
    logic [5:0]  out2;
    logic [5:0]  out3;
    logic        pred;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'h01, 8'hFF, 13'h0043, 4'h0, 1'b0, 1'b1, 1'b1, 6'h01, 6'h00, 1'b0},
    '{8'h84, 8'hFF, 13'h0CE1, 4'hE, 1'b0, 1'b1, 1'b1, 6'h24, 6'h00, 1'b1},
    '{8'h20, 8'hFF, 13'h0110, 4'h4, 1'b0, 1'b1, 1'b1, 6'h00, 6'h08, 1'b0},
    '{8'h0A, 8'hFF, 13'h0485, 4'h1, 1'b1, 1'b1, 1'b1, 6'h02, 6'h00, 1'b0},
    '{8'h01, 8'h00, 13'h1043, 4'h0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, 1'b0},
    '{8'h11, 8'hFF, 13'h1043, 4'h0, 1'b0, 1'b1, 1'b1, 6'h01, 6'h00, 1'b0},
    '{8'h01, 8'h00, 13'h0043, 4'h0, 1'b0, 1'b1, 1'b0, 6'h01, 6'h00, 1'b0},
    '{8'h12, 8'h02, 13'h0043, 4'h1, 1'b0, 1'b1, 1'b0, 6'h01, 6'h00, 1'b0},
    '{8'h40, 8'hFF, 13'h0007, 4'h8, 1'b0, 1'b1, 1'b1, 6'h00, 6'h00, 1'b0},
    '{8'hF0, 8'hFF, 13'h0043, 4'h0, 1'b1, 1'b1, 1'b1, 6'h01, 6'h00, 1'b0}
  };

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [5:0] tok, input logic pred, input logic stg);
    chk(req, 32'(out_tok), 32'(tok));
    chk({req, " R8 pred"}, 32'(out_pred), pred ? 32'(tok) : 32'h0);
    chk({req, " R9 stage"}, 32'(out_stage), stg ? 32'(tok) : 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_slot = '0; in_tok = '0; in_stage = '0; fetch_data = '0;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 fetch_en", 32'(fetch_en), 0);
    chk("R11 valid", 32'(exec_valid), 0);
    chk("R11 sel", 32'(exec_sel), 0);
    chk("R11 opcode", 32'(exec_opcode), 0);
    chk("R11 err", 32'(sel_err), 0);
    chk("R11 out", 32'({out_tok, out_pred, out_stage, exec_stage}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_tok = VEC[i].tok; in_stage = VEC[i].stg; cfg_slot = ADDR_W'(i + 3);
      #1;
      chk("R1 fetch_en", 32'(fetch_en), 1);
      chk("R1 fetch_addr", 32'(fetch_addr), 32'(i + 3));
      @(negedge clk);
      in_tok = '0; in_stage = '0; fetch_data = VEC[i].data;
      #1;
      chk("R4 R10 valid", 32'(exec_valid), 32'(VEC[i].vld));
      chk("R2 sel", 32'(exec_sel), 32'(VEC[i].sel));
      chk("R3 err", 32'(sel_err), 32'(VEC[i].err));
      chk("R4 opcode", 32'(exec_opcode), 32'(VEC[i].data[5:0]));
      chk("R9 exec_stage", 32'(exec_stage), 32'(VEC[i].estg));
      chk("R1 idle fetch", 32'(fetch_en), 0);
      @(negedge clk);
      fetch_data = 13'h1FFF;   // junk that must be ignored
      #1;
      chk_out("R6 R7 short", VEC[i].out2, VEC[i].pred, VEC[i].estg);
      chk("R5 hold", 32'(exec_opcode), 32'(VEC[i].data[5:0]));
      chk("R4 no valid", 32'(exec_valid), 0);
      @(negedge clk);
      #1;
      chk_out("R7 long", VEC[i].out3, VEC[i].pred, VEC[i].estg);
      chk("R5 hold2", 32'(exec_opcode), 32'(VEC[i].data[5:0]));
      @(negedge clk);
      fetch_data = '0;
      #1;
      chk("R7 drained", 32'(out_tok), 0);
    end

    // R7: long op followed at once by short op, both due in the same cycle
    @(negedge clk);
    in_tok = 8'h20; in_stage = 8'hFF;
    @(negedge clk);
    in_tok = 8'h01; fetch_data = 13'h0110;
    #1;
    chk("R4 b2b valid", 32'(exec_valid), 1);
    chk("R1 b2b fetch", 32'(fetch_en), 1);
    @(negedge clk);
    in_tok = '0; fetch_data = 13'h0043;
    #1;
    chk("R7 b2b mid", 32'(out_tok), 0);
    chk("R4 b2b opc", 32'(exec_opcode), 32'h03);
    @(negedge clk);
    fetch_data = '0;
    #1;
    chk("R7 merge", 32'(out_tok), 32'h09);
    @(negedge clk);
    #1;
    chk("R7 merge end", 32'(out_tok), 0);

    // R1: no tokens for several cycles -> no fetch, no execute
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fetch_data = 13'h0FFF;
      #1;
      chk("R1 quiet fetch", 32'(fetch_en), 0);
      chk("R4 quiet valid", 32'(exec_valid), 0);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule